// File: doc/BRIEF.md
# Infrared Pulse-Distance Serial PHY

This block is the physical layer of a short-range optical link that codes each bit as the silent interval after a short light pulse. Every pulse is exactly one clock cycle wide. A short interval after the pulse means 0 and a long interval means 1. The interval is counted from the clock after the pulse until the next pulse rises, so the last bit of a burst is closed by one extra terminating pulse. A burst begins with a start pulse followed by a header interval that is longer than any data interval. All bytes queued back to back are sent behind that single header, least significant bit first. After the terminating pulse the line stays dark for a guard time before another header may start.

On the transmit side, bytes enter a queue of 32 entries through a valid/ready port. A transfer takes place on a clock edge where `s_valid` and `s_ready` are both high. `s_ready` falls only when the queue is full, and while it is low the offered byte stays on `s_data` until it is taken. On the receive side, a synchronised sensor line is timed between rising edges. Intervals are classified against tolerance windows. Rebuilt bytes go into a second queue of 32 entries, drained through `m_valid`/`m_ready`. Once raised, `m_valid` stays high and `m_data` stays unchanged until the byte is taken.

Receive problems are reported on plain pins. `rx_err_o` is a sticky flag raised by a bad interval or by a byte lost to a full receive queue, and `rx_err_clr_i` clears it. `rx_timeout_o` is a one-cycle pulse given when the line goes quiet in the middle of a byte.

Top module: `irpd_phy`

## Requirements
- R1: After reset the light output and `tx_busy_o` are low, `s_ready` is high, `m_valid` is low and `rx_err_o` is low.
- R2: The transmit queue accepts 32 bytes offered on consecutive cycles without lowering `s_ready`, even while the link is sending.
- R3: Every burst opens with a one-cycle start pulse followed by 12 dark cycles. No other interval on the output has that length.
- R4: Every output pulse is one cycle wide. A 0 bit is followed by 3 dark cycles and a 1 bit by 6, and bits go out LSB first.
- R5: Bytes that are queued back to back share one header. After the last bit interval, one terminating pulse is sent, then at least 24 dark cycles pass before the next start pulse.
- R6: The receiver reads an interval of 10 to 14 cycles after a preceding pulse as a header. Inside a frame it reads 2 to 4 cycles as 0 and 5 to 8 cycles as 1, LSB first, and delivers each completed byte in order on `m_data`.
- R7: Input pulses one clock cycle wide are detected. A burst from the transmitter looped back to the sensor input is received as the same bytes, with no error and no timeout.
- R8: Inside a frame, an interval of any other length (for example 9 cycles) drops the partial byte, raises `rx_err_o` and stops decoding until a new header. `rx_err_o` stays high until `rx_err_clr_i` is pulsed.
- R9: If the sensor line stays dark for 20 cycles inside a frame with a partial byte, `rx_timeout_o` pulses once, the partial byte is dropped and the receiver waits for a new header. A quiet line after a complete byte gives no timeout.
- R10: `m_valid` with unchanged `m_data` is held until `m_ready`. `s_ready` is low while the transmit queue is full, and bytes offered then are taken later without loss.
- R11: A header interval seen in the middle of a byte discards the bits collected so far and restarts the byte.
- R12: A byte completed while the receive queue holds 32 bytes is dropped and raises `rx_err_o`. The 32 stored bytes are kept in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Transmit byte offered |
| s_ready | output | 1 | Transmit queue can take a byte |
| s_data | input | 8 | Transmit byte |
| ir_tx_o | output | 1 | Light emitter drive, high for a pulse |
| tx_busy_o | output | 1 | Transmitter is sending a burst or guard time |
| ir_rx_i | input | 1 | Digitised sensor line, asynchronous |
| m_valid | output | 1 | Received byte available |
| m_ready | input | 1 | Consumer takes the received byte |
| m_data | output | 8 | Received byte |
| rx_timeout_o | output | 1 | One-cycle pulse: line went quiet in mid-byte |
| rx_err_o | output | 1 | Sticky receive error |
| rx_err_clr_i | input | 1 | Clears the sticky receive error |

## Verification
The bench decodes the emitter line on its own and checks every interval. A transmitter that produced a two-cycle pulse, a guard that was too short, or a missing terminating pulse would leave a byte unfinished or show an illegal interval. Receive stimulus is injected at the edges of each tolerance window (2, 4, 5, 8, 10 and 14 cycles) and just outside them (9 cycles). A receiver with an off-by-one window would drop or corrupt those bytes. Other directed frames stop mid-byte, restart a byte with a second header, and overfill the receive queue. A receiver that kept stale bits, missed the timeout or overwrote stored data would deliver an extra or wrong byte there. Random bursts, with random pauses on both the offer and drain sides, exercise back-pressure and the grouping of bytes behind one header.

// File: rtl/irpd_pkg.sv
package irpd_pkg;

  localparam int unsigned IRPD_DATA_W     = 8;
  localparam int unsigned IRPD_FIFO_DEPTH = 32;
  localparam int unsigned IRPD_GAP_ZERO   = 3;
  localparam int unsigned IRPD_GAP_ONE    = 6;
  localparam int unsigned IRPD_GAP_HDR    = 12;
  localparam int unsigned IRPD_GUARD      = 24;
  localparam int unsigned IRPD_TIMEOUT    = 20;

  typedef enum logic [2:0] {
    TX_IDLE,
    TX_HDR_PULSE,
    TX_HDR_GAP,
    TX_BIT_PULSE,
    TX_BIT_GAP,
    TX_END_PULSE,
    TX_GUARD
  } tx_state_e;

  typedef enum logic {
    RX_HUNT,
    RX_FRAME
  } rx_state_e;

endpackage

// File: rtl/irpd_fifo.sv
module irpd_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wr_ptr, rd_ptr;
  logic [AW:0]  fill;
  logic         full, empty, do_push, do_pop;

  assign fill      = wr_ptr - rd_ptr;
  assign full      = (fill == FULL_CNT);
  assign empty     = (fill == '0);
  assign in_ready  = !full;
  assign out_valid = !empty;
  assign out_data  = mem[rd_ptr[AW-1:0]];
  assign do_push   = in_valid && !full;
  assign do_pop    = out_ready && !empty;

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr[AW-1:0]] <= in_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
    end
  end

  // R2: occupancy never exceeds the queue depth
  a_r2_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= FULL_CNT);

  // R2: a full queue stays full until something is read
  a_r2_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !out_ready) |=> full);

  // R10: an offered output byte is held stable until taken
  a_r10_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

endmodule

// File: rtl/irpd_tx.sv
module irpd_tx
  import irpd_pkg::*;
#(
  parameter int unsigned DW       = 8,
  parameter int unsigned GAP_ZERO = 3,
  parameter int unsigned GAP_ONE  = 6,
  parameter int unsigned GAP_HDR  = 12,
  parameter int unsigned GUARD    = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          ir_o,
  output logic          busy_o
);
  localparam int unsigned CW = $clog2(GUARD + GAP_HDR + GAP_ONE + 1);
  localparam int unsigned BW = $clog2(DW);
  localparam logic [CW-1:0] G0_M1 = CW'(GAP_ZERO - 1);
  localparam logic [CW-1:0] G1_M1 = CW'(GAP_ONE - 1);
  localparam logic [CW-1:0] GH_M1 = CW'(GAP_HDR - 1);
  localparam logic [CW-1:0] GD_M1 = CW'(GUARD - 1);
  localparam logic [BW-1:0] LAST_BIT = BW'(DW - 1);

  tx_state_e     state;
  logic [CW-1:0] gcnt;
  logic [DW-1:0] shreg;
  logic [BW-1:0] bitidx;
  logic          gap_done, last_bit;

  assign gap_done = (gcnt == '0);
  assign last_bit = (bitidx == LAST_BIT);
  assign in_ready = gap_done &&
                    ((state == TX_HDR_GAP) ||
                     (state == TX_BIT_GAP && last_bit && in_valid));
  assign ir_o     = (state == TX_HDR_PULSE) || (state == TX_BIT_PULSE) ||
                    (state == TX_END_PULSE);
  assign busy_o   = (state != TX_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= TX_IDLE;
      gcnt   <= '0;
      shreg  <= '0;
      bitidx <= '0;
    end else begin
      case (state)
        TX_IDLE: begin
          if (in_valid) state <= TX_HDR_PULSE;
        end
        TX_HDR_PULSE: begin
          state <= TX_HDR_GAP;
          gcnt  <= GH_M1;
        end
        TX_HDR_GAP: begin
          if (gap_done) begin
            shreg  <= in_data;
            bitidx <= '0;
            state  <= TX_BIT_PULSE;
          end else begin
            gcnt <= gcnt - 1'b1;
          end
        end
        TX_BIT_PULSE: begin
          state <= TX_BIT_GAP;
          gcnt  <= shreg[0] ? G1_M1 : G0_M1;
        end
        TX_BIT_GAP: begin
          if (!gap_done) begin
            gcnt <= gcnt - 1'b1;
          end else if (!last_bit) begin
            shreg  <= shreg >> 1;
            bitidx <= bitidx + 1'b1;
            state  <= TX_BIT_PULSE;
          end else if (in_valid) begin
            shreg  <= in_data;
            bitidx <= '0;
            state  <= TX_BIT_PULSE;
          end else begin
            state <= TX_END_PULSE;
          end
        end
        TX_END_PULSE: begin
          state <= TX_GUARD;
          gcnt  <= GD_M1;
        end
        TX_GUARD: begin
          if (gap_done) state <= TX_IDLE;
          else          gcnt  <= gcnt - 1'b1;
        end
        default: state <= TX_IDLE;
      endcase
    end
  end

  // Checker: dark-run length seen on the output, kept apart from the FSM
  localparam logic [CW-1:0] CK_G0 = CW'(GAP_ZERO);
  localparam logic [CW-1:0] CK_G1 = CW'(GAP_ONE);
  localparam logic [CW-1:0] CK_GH = CW'(GAP_HDR);
  localparam logic [CW-1:0] CK_GD = CW'(GUARD);
  logic [CW-1:0] ck_dark;
  logic          ck_prev, ck_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ck_dark <= '0;
      ck_prev <= 1'b0;
      ck_seen <= 1'b0;
    end else begin
      ck_prev <= ir_o;
      if (ir_o) begin
        ck_dark <= '0;
        ck_seen <= 1'b1;
      end else if (ck_dark != CK_GD) begin
        ck_dark <= ck_dark + 1'b1;
      end
    end
  end

  // R4: pulses are a single cycle wide
  a_r4_one_cycle_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ir_o |=> !ir_o);

  // R3, R4, R5: every dark run before a pulse has a legal length
  a_r4_gap_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (ir_o && !ck_prev && ck_seen) |->
      (ck_dark == CK_G0 || ck_dark == CK_G1 || ck_dark == CK_GH ||
       ck_dark == CK_GD));

  // R5: a byte is only taken when one is offered
  a_r5_pop_has_data: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> in_valid || state == TX_HDR_GAP);

endmodule

// File: rtl/irpd_rx.sv
module irpd_rx
  import irpd_pkg::*;
#(
  parameter int unsigned DW        = 8,
  parameter int unsigned SYNC      = 2,
  parameter int unsigned ZERO_MIN  = 2,
  parameter int unsigned ZERO_MAX  = 4,
  parameter int unsigned ONE_MIN   = 5,
  parameter int unsigned ONE_MAX   = 8,
  parameter int unsigned HDR_MIN   = 10,
  parameter int unsigned HDR_MAX   = 14,
  parameter int unsigned TIMEOUT   = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ir_i,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic          timeout_o,
  output logic          err_o,
  input  logic          err_clr_i
);
  localparam int unsigned CW = $clog2(TIMEOUT + 1);
  localparam int unsigned BW = $clog2(DW);
  localparam logic [CW-1:0] SAT  = CW'(TIMEOUT);
  localparam logic [CW-1:0] Z_LO = CW'(ZERO_MIN);
  localparam logic [CW-1:0] Z_HI = CW'(ZERO_MAX);
  localparam logic [CW-1:0] O_LO = CW'(ONE_MIN);
  localparam logic [CW-1:0] O_HI = CW'(ONE_MAX);
  localparam logic [CW-1:0] H_LO = CW'(HDR_MIN);
  localparam logic [CW-1:0] H_HI = CW'(HDR_MAX);
  localparam logic [BW-1:0] LAST_BIT = BW'(DW - 1);

  // Synchroniser chain for the asynchronous sensor line
  logic [SYNC-1:0] sync_q;
  genvar gi;
  generate
    for (gi = 0; gi < SYNC; gi++) begin : g_sync
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q[gi] <= 1'b0;
        else if (gi == 0) sync_q[gi] <= ir_i;
        else sync_q[gi] <= sync_q[(gi == 0) ? 0 : gi - 1];
      end
    end
  endgenerate

  logic line, line_d, rise;
  assign line = sync_q[SYNC-1];
  assign rise = line && !line_d;

  rx_state_e     state;
  logic [CW-1:0] dark;
  logic [DW-1:0] shreg;
  logic [BW-1:0] bitcnt;
  logic          seen;
  logic          push_q;
  logic [DW-1:0] push_data;
  logic          is_hdr, is_zero, is_one, quiet;
  logic          bad_gap, drop;

  assign is_hdr  = (dark >= H_LO) && (dark <= H_HI);
  assign is_zero = (dark >= Z_LO) && (dark <= Z_HI);
  assign is_one  = (dark >= O_LO) && (dark <= O_HI);
  assign quiet   = !line && (dark == SAT);
  assign bad_gap = (state == RX_FRAME) && rise && !is_hdr && !is_zero && !is_one;
  assign drop    = push_q && !out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_d <= 1'b0;
      dark   <= '0;
    end else begin
      line_d <= line;
      if (line)            dark <= '0;
      else if (dark != SAT) dark <= dark + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= RX_HUNT;
      shreg     <= '0;
      bitcnt    <= '0;
      seen      <= 1'b0;
      push_q    <= 1'b0;
      push_data <= '0;
      timeout_o <= 1'b0;
    end else begin
      push_q    <= 1'b0;
      timeout_o <= 1'b0;
      case (state)
        RX_HUNT: begin
          if (rise) begin
            seen <= 1'b1;
            if (seen && is_hdr) begin
              state  <= RX_FRAME;
              bitcnt <= '0;
            end
          end else if (quiet) begin
            seen <= 1'b0;
          end
        end
        RX_FRAME: begin
          if (rise) begin
            if (is_hdr) begin
              bitcnt <= '0;
            end else if (is_zero || is_one) begin
              shreg <= {is_one, shreg[DW-1:1]};
              if (bitcnt == LAST_BIT) begin
                push_q    <= 1'b1;
                push_data <= {is_one, shreg[DW-1:1]};
                bitcnt    <= '0;
              end else begin
                bitcnt <= bitcnt + 1'b1;
              end
            end else begin
              state <= RX_HUNT;
            end
          end else if (quiet) begin
            state     <= RX_HUNT;
            seen      <= 1'b0;
            timeout_o <= (bitcnt != '0);
          end
        end
        default: state <= RX_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                err_o <= 1'b0;
    else if (bad_gap || drop)  err_o <= 1'b1;
    else if (err_clr_i)        err_o <= 1'b0;
  end

  assign out_valid = push_q;
  assign out_data  = push_data;

  // R8: the error flag holds until cleared
  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o && !err_clr_i) |=> err_o);

  // R9: a timeout is only reported after a dark line
  a_r9_timeout_dark: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |-> !line_d);

  // R6: a byte is only produced right after a detected rising edge
  a_r6_push_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    push_q |-> $past(rise));

  // R12: a dropped byte always leaves the error flag raised
  a_r12_drop_flags: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> err_o);

endmodule

// File: rtl/irpd_phy.sv
module irpd_phy
  import irpd_pkg::*;
#(
  parameter int unsigned DW            = IRPD_DATA_W,
  parameter int unsigned TX_DEPTH      = IRPD_FIFO_DEPTH,
  parameter int unsigned RX_DEPTH      = IRPD_FIFO_DEPTH,
  parameter int unsigned GAP_ZERO      = IRPD_GAP_ZERO,
  parameter int unsigned GAP_ONE       = IRPD_GAP_ONE,
  parameter int unsigned GAP_HDR       = IRPD_GAP_HDR,
  parameter int unsigned GUARD         = IRPD_GUARD,
  parameter int unsigned TIMEOUT       = IRPD_TIMEOUT,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [DW-1:0] s_data,
  output logic          ir_tx_o,
  output logic          tx_busy_o,
  input  logic          ir_rx_i,
  output logic          m_valid,
  input  logic          m_ready,
  output logic [DW-1:0] m_data,
  output logic          rx_timeout_o,
  output logic          rx_err_o,
  input  logic          rx_err_clr_i
);
  logic          txq_valid, txq_ready;
  logic [DW-1:0] txq_data;
  logic          rxq_valid, rxq_ready;
  logic [DW-1:0] rxq_data;

  irpd_fifo #(.W(DW), .DEPTH(TX_DEPTH)) u_tx_fifo (
    .clk(clk), .rst_n(rst_n),
    .in_valid(s_valid), .in_ready(s_ready), .in_data(s_data),
    .out_valid(txq_valid), .out_ready(txq_ready), .out_data(txq_data)
  );

  irpd_tx #(
    .DW(DW), .GAP_ZERO(GAP_ZERO), .GAP_ONE(GAP_ONE),
    .GAP_HDR(GAP_HDR), .GUARD(GUARD)
  ) u_tx (
    .clk(clk), .rst_n(rst_n),
    .in_valid(txq_valid), .in_ready(txq_ready), .in_data(txq_data),
    .ir_o(ir_tx_o), .busy_o(tx_busy_o)
  );

  irpd_rx #(
    .DW(DW), .SYNC(SYNC_STAGES), .TIMEOUT(TIMEOUT)
  ) u_rx (
    .clk(clk), .rst_n(rst_n), .ir_i(ir_rx_i),
    .out_valid(rxq_valid), .out_ready(rxq_ready), .out_data(rxq_data),
    .timeout_o(rx_timeout_o), .err_o(rx_err_o), .err_clr_i(rx_err_clr_i)
  );

  irpd_fifo #(.W(DW), .DEPTH(RX_DEPTH)) u_rx_fifo (
    .clk(clk), .rst_n(rst_n),
    .in_valid(rxq_valid), .in_ready(rxq_ready), .in_data(rxq_data),
    .out_valid(m_valid), .out_ready(m_ready), .out_data(m_data)
  );

  // R1: nothing is emitted or delivered in the cycle after reset
  a_r1_quiet_after_reset: assert property (@(posedge clk)
    $rose(rst_n) |-> (!ir_tx_o && !m_valid && s_ready));

endmodule

// File: tb/irpd_phy_bench.sv
module irpd_phy_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s_valid = 1'b0;
  logic [7:0] s_data = '0;
  logic s_ready, ir_tx, tx_busy, m_valid, rx_timeout, rx_err;
  logic [7:0] m_data;
  logic m_ready = 1'b0;
  logic rx_err_clr = 1'b0;
  logic inj_sel = 1'b0;
  logic inj = 1'b0;
  logic rx_line;

  always #5 clk = ~clk;

  assign rx_line = inj_sel ? inj : ir_tx;

  irpd_phy u_irpd_phy (
    .clk(clk), .rst_n(rst_n),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .ir_tx_o(ir_tx), .tx_busy_o(tx_busy), .ir_rx_i(rx_line),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
    .rx_timeout_o(rx_timeout), .rx_err_o(rx_err), .rx_err_clr_i(rx_err_clr)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Expected streams
  logic [7:0] tx_exp [512];
  logic [7:0] rx_exp [512];
  logic [7:0] tx_got [512];
  logic [7:0] rx_got [512];
  int tx_exp_n = 0, rx_exp_n = 0, tx_got_n = 0, rx_got_n = 0;
  int tx_chk = 0, rx_chk = 0;

  // Emitter monitor: independent decode of the light output
  int dark = 0, hdr_cnt = 0, gap_bad = 0, wide_bad = 0, term_bad = 0;
  int mon_bits = 0;
  logic [7:0] mon_byte = '0;
  bit tx_prev = 0, pulsed = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      dark = 0; tx_prev = 0; pulsed = 0; mon_bits = 0;
    end else begin
      if (ir_tx && tx_prev) wide_bad++;
      if (ir_tx && !tx_prev) begin
        if (pulsed) begin
          if (dark == 12) begin
            hdr_cnt++; mon_bits = 0;
          end else if (dark == 3 || dark == 6) begin
            mon_byte = {(dark == 6), mon_byte[7:1]};
            mon_bits++;
            if (mon_bits == 8) begin
              tx_got[tx_got_n] = mon_byte; tx_got_n++; mon_bits = 0;
            end
          end else if (dark >= 24) begin
            if (mon_bits != 0) term_bad++;
          end else begin
            gap_bad++;
          end
        end
        pulsed = 1;
      end
      if (ir_tx) dark = 0; else dark++;
      tx_prev = ir_tx;
    end
  end

  // Receive collector and back-pressure driver
  int rdy_mode = 2;   // 0 hold off, 1 random, 2 always
  int hold_bad = 0, tmo_cnt = 0;
  bit prev_wait = 0;
  logic [7:0] prev_data = '0;

  always @(negedge clk) begin
    bit rdy;
    if (rst_n) begin
      if (rx_timeout) tmo_cnt++;
      if (prev_wait && (!m_valid || m_data != prev_data)) hold_bad++;
      rdy = (rdy_mode == 2) || (rdy_mode == 1 && ($urandom % 2 == 0));
      m_ready = rdy;
      if (m_valid && rdy) begin
        rx_got[rx_got_n] = m_data; rx_got_n++;
      end
      prev_wait = m_valid && !rdy;
      prev_data = m_data;
    end
  end

  int stalls = 0;

  task automatic send(input logic [7:0] b);
    s_data = b; s_valid = 1'b1;
    while (!s_ready) begin stalls++; @(negedge clk); end
    @(negedge clk);
    s_valid = 1'b0;
    tx_exp[tx_exp_n] = b; tx_exp_n++;
    rx_exp[rx_exp_n] = b; rx_exp_n++;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
    while (tx_busy) @(negedge clk);
    repeat (40) @(negedge clk);
    while (m_valid) @(negedge clk);
    repeat (5) @(negedge clk);
  endtask

  task automatic cmp_tx(input string req);
    check(tx_got_n == tx_exp_n, req, tx_got_n, tx_exp_n);
    for (int i = tx_chk; i < tx_got_n && i < tx_exp_n; i++)
      check(tx_got[i] == tx_exp[i], req, tx_got[i], tx_exp[i]);
    tx_chk = tx_got_n;
  endtask

  task automatic cmp_rx(input string req);
    check(rx_got_n == rx_exp_n, req, rx_got_n, rx_exp_n);
    for (int i = rx_chk; i < rx_got_n && i < rx_exp_n; i++)
      check(rx_got[i] == rx_exp[i], req, rx_got[i], rx_exp[i]);
    rx_chk = rx_got_n;
  endtask

  // Injected sensor waveform: one-cycle pulse then g dark cycles
  task automatic pg(input int g);
    inj = 1'b1; @(negedge clk);
    inj = 1'b0; repeat (g) @(negedge clk);
  endtask

  function automatic int gap_of(input bit v, input bit wide_end);
    if (v) return wide_end ? 8 : 5;
    return wide_end ? 4 : 2;
  endfunction

  task automatic inj_byte(input logic [7:0] b, input int g0, input int g1);
    for (int i = 0; i < 8; i++) pg(b[i] ? g1 : g0);
  endtask

  function automatic logic [7:0] ovf_val(input int i);
    return 8'(i * 7 + 1);
  endfunction

  initial begin
    int unsigned seed_sink;
    int base_hdr;
    seed_sink = $urandom(32'd4711);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(ir_tx == 1'b0, "R1 tx idle", ir_tx, 0);
    check(tx_busy == 1'b0, "R1 busy", tx_busy, 0);
    check(s_ready == 1'b1, "R1 s_ready", s_ready, 1);
    check(m_valid == 1'b0, "R1 m_valid", m_valid, 0);
    check(rx_err == 1'b0, "R1 err", rx_err, 0);

    // R3 R4 R7: isolated bytes, each its own burst
    send(8'h00); settle();
    send(8'hFF); settle();
    send(8'hA5); settle();
    check(hdr_cnt == 3, "R3 headers", hdr_cnt, 3);
    cmp_tx("R4 tx bytes");
    cmp_rx("R7 loopback");

    // R5: back-to-back bytes share one header
    base_hdr = hdr_cnt;
    for (int i = 0; i < 5; i++) send(8'(8'h31 + i * 17));
    settle();
    check(hdr_cnt - base_hdr == 1, "R5 one header", hdr_cnt - base_hdr, 1);
    check(term_bad == 0, "R5 terminator", term_bad, 0);
    cmp_tx("R5 tx bytes");
    cmp_rx("R5 rx bytes");

    // R2 R10: 40 consecutive offers
    rdy_mode = 1;
    stalls = 0;
    for (int i = 0; i < 40; i++) begin
      send(8'($urandom));
      if (i == 31) check(stalls == 0, "R2 no stall in 32", stalls, 0);
    end
    check(stalls > 0, "R10 s_ready back-pressure", stalls, 1);
    settle();
    cmp_tx("R10 tx bytes");
    cmp_rx("R10 rx bytes");

    // Random bursts with random pauses
    for (int b = 0; b < 6; b++) begin
      int len;
      len = 1 + int'($urandom % 12);
      for (int i = 0; i < len; i++) begin
        send(8'($urandom));
        repeat ($urandom % 3) @(negedge clk);
      end
      repeat ($urandom % 200) @(negedge clk);
    end
    settle();
    cmp_tx("R4 random tx");
    cmp_rx("R7 random rx");
    check(gap_bad == 0, "R4 gap lengths", gap_bad, 0);
    check(wide_bad == 0, "R4 pulse width", wide_bad, 0);
    check(term_bad == 0, "R5 guard", term_bad, 0);
    check(hold_bad == 0, "R10 m hold", hold_bad, 0);
    check(tmo_cnt == 0, "R9 no timeout on clean frames", tmo_cnt, 0);
    check(rx_err == 0, "R7 no error", rx_err, 0);

    // Injected receive cases
    rdy_mode = 2;
    inj_sel = 1'b1;
    repeat (30) @(negedge clk);

    // R6: window edges, 0x6A with gaps 2/4 for 0 and 5/8 for 1
    pg(10);
    pg(gap_of(0,0)); pg(gap_of(1,0)); pg(gap_of(0,1)); pg(gap_of(1,1));
    pg(gap_of(0,0)); pg(gap_of(1,1)); pg(gap_of(1,0)); pg(gap_of(0,1));
    pg(30);
    rx_exp[rx_exp_n] = 8'h6A; rx_exp_n++;
    pg(14); inj_byte(8'h6A, 4, 8); pg(30);
    rx_exp[rx_exp_n] = 8'h6A; rx_exp_n++;
    repeat (5) @(negedge clk);
    cmp_rx("R6 windows");
    check(rx_err == 0, "R6 no error", rx_err, 0);

    // R9: quiet mid-byte
    pg(12); pg(3); pg(6); pg(3); pg(30);
    check(tmo_cnt == 1, "R9 timeout pulse", tmo_cnt, 1);
    pg(12); inj_byte(8'hC3, 3, 6); pg(30);
    rx_exp[rx_exp_n] = 8'hC3; rx_exp_n++;
    repeat (5) @(negedge clk);
    cmp_rx("R9 drop partial");
    check(tmo_cnt == 1, "R9 no timeout after whole byte", tmo_cnt, 1);

    // R11: header mid-byte restarts the byte
    pg(12); pg(3); pg(6); pg(3); pg(12); inj_byte(8'h3C, 3, 6); pg(30);
    rx_exp[rx_exp_n] = 8'h3C; rx_exp_n++;
    repeat (5) @(negedge clk);
    cmp_rx("R11 resync");
    check(rx_err == 0, "R11 no error", rx_err, 0);

    // R8: illegal 9-cycle gap
    pg(12); pg(3); pg(9); pg(3); pg(3); pg(3); pg(30);
    check(rx_err == 1, "R8 err raised", rx_err, 1);
    cmp_rx("R8 partial dropped");
    pg(12); inj_byte(8'h5E, 3, 6); pg(30);
    rx_exp[rx_exp_n] = 8'h5E; rx_exp_n++;
    repeat (5) @(negedge clk);
    cmp_rx("R8 recovers at header");
    check(rx_err == 1, "R8 err sticky", rx_err, 1);
    rx_err_clr = 1'b1; @(negedge clk); rx_err_clr = 1'b0;
    check(rx_err == 0, "R8 err cleared", rx_err, 0);

    // R12: overflow of the receive queue
    rdy_mode = 0;
    repeat (2) @(negedge clk);
    pg(12);
    for (int i = 0; i < 33; i++) inj_byte(ovf_val(i), 3, 6);
    pg(30);
    check(rx_err == 1, "R12 overflow err", rx_err, 1);
    check(m_valid == 1, "R12 data kept", m_valid, 1);
    for (int i = 0; i < 32; i++) begin
      rx_exp[rx_exp_n] = ovf_val(i); rx_exp_n++;
    end
    rdy_mode = 1;
    repeat (150) @(negedge clk);
    cmp_rx("R12 first 32 kept");
    check(hold_bad == 0, "R10 m hold", hold_bad, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < 150000; c++) @(negedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule